// File: doc/BRIEF.md
# Watchdog Periodic Timer

This block is a timer for a real-time-clock device. It serves two purposes. It can run as a periodic interrupt source, and it can also act as a watchdog that software must keep restarting. It counts a slow prescaled tick, 32.768 kHz by default, presented as a one-cycle enable. A 4-bit configuration word holds an enable bit and a 3-bit period code. Each step of the period code halves the timer cycle. The base cycle is 625 ms, and code 7 gives about 4.88 ms.

Counting uses two stages. A low-order prescaler always runs, and an upper unit counter counts ten prescaler periods. A restart clears only the unit counter, so the first expiry after a restart falls between nine and ten prescaler periods. Three events cause a restart:
- a timer-reset strobe;
- a rising edge on the chip-enable input;
- disabling the timer.

When the timer expires it sets a sticky flag and drives the active-low timer pin low. The flag clears on a restart or on any write to the configuration word. A read returns the enable bit, two zero bits and the flag.

Top module: `wdt_periodic_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the enable bit and the flag are cleared. After reset, `rdata_o` reads 4'b0000 and `tmout_n_o` is 1.
- R2: A write (`wr_i`=1) stores `wdata_i[3]` as the enable bit and `wdata_i[2:0]` as the period code. `rdata_o` is {enable, 0, 0, flag}, so the period code is never read back.
- R3: While the enable bit is 0, the flag stays 0 and `tmout_n_o` stays 1 for any period code and any tick activity.
- R4: With the enable bit at 1 and no restart, expiries repeat every 10 x 2^(PRE_W-code) ticks.
- R5: After a restart, the first expiry occurs after more than 9 x 2^(PRE_W-code) ticks and at most 10 x 2^(PRE_W-code) ticks.
- R6: Each of these restarts the count and clears the flag: a `tmr_rst_i` pulse, a 0-to-1 transition of `ce_i`, and a write with `wdata_i[3]`=0.
- R7: An expiry sets the flag in the clock edge where it happens. The flag then holds until a restart or a write, and `tmout_n_o` is always the inverse of the flag.
- R8: When a restart and an expiry fall on the same edge, the restart wins: the flag stays 0 and a full count begins. When a write and an expiry fall on the same edge, the expiry wins and the flag is 1.
- R9: The counters advance only on edges where `tick_i` is 1. Without ticks, no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable at the prescaled tick rate |
| wr_i | input | 1 | Write strobe for the configuration word |
| wdata_i | input | 4 | Write data: bit 3 enable, bits 2:0 period code |
| tmr_rst_i | input | 1 | Timer-reset strobe from the control register |
| ce_i | input | 1 | Chip-enable level; a rising edge restarts the timer |
| rdata_o | output | 4 | Read data: {enable, 0, 0, flag} |
| tmout_n_o | output | 1 | Active-low timer output, inverse of the flag |

## Verification
An expiry can land on the same edge as a restart strobe, and it can also land on the same edge as a register write. The bench provokes both with period code 7, where the prescaler strobes on every tick. In that setting the tenth edge after a restart is known exactly, and the bench lines up a `tmr_rst_i` pulse or a write on that edge. A behavioural model compares the results cycle by cycle. Directed checks then confirm that the pin stays high after the restart collision and goes low after the write collision.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Stored configuration word
    typedef struct packed {
        logic       en;
        logic [2:0] code;
    } wdt_cfg_t;

    localparam int CFG_W  = 4;
    localparam int CODE_W = 3;

    // Mask with the low span_bits bits set
    function automatic logic [31:0] low_mask(input int unsigned span_bits);
        return (32'd1 << span_bits) - 32'd1;
    endfunction

    // Read word: enable, two zero bits, flag
    function automatic logic [CFG_W-1:0] read_word(input wdt_cfg_t cfg, input logic flag);
        return {cfg.en, 2'b00, flag};
    endfunction

    function automatic wdt_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
        wdt_cfg_t c;
        c.en   = w[3];
        c.code = w[2:0];
        return c;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int PRE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              strobe_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask_c;
    logic [31:0]      full_c;
    int unsigned      span_c;

    always_comb begin
        span_c = PRE_W - int'(code_i);
        full_c = low_mask(span_c);
        mask_c = full_c[PRE_W-1:0];
    end

    assign strobe_o = tick_i && ((pre_q & mask_c) == mask_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R9: prescaler holds without a tick
    p_pre_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pre_q));

endmodule

// File: rtl/wdt_unit_counter.sv
module wdt_unit_counter #(
    parameter int UNITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic strobe_i,
    output logic expire_o
);
    localparam int UW = (UNITS > 1) ? $clog2(UNITS) : 1;
    localparam logic [UW-1:0] LAST = UW'(UNITS - 1);

    logic [UW-1:0] unit_q;
    logic          at_last;

    assign at_last  = (unit_q == LAST);
    assign expire_o = strobe_i && at_last && !restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            unit_q <= '0;
        end else if (strobe_i) begin
            unit_q <= at_last ? '0 : unit_q + 1'b1;
        end
    end

    // R4: count stays within its modulus
    p_unit_range_r4: assert property (@(posedge clk) disable iff (rst)
        unit_q <= LAST);
    // R5: restart empties the unit stage
    p_restart_zero_r5: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (unit_q == '0));
    // R9: no progress without a prescaler strobe
    p_unit_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!strobe_i && !restart_i) |=> $stable(unit_q));

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic expire_i,
    input  logic wr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            flag_q <= 1'b0;
        end else if (expire_i) begin
            flag_q <= 1'b1;
        end else if (wr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    // R6: restart clears the flag
    p_restart_clear_r6: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !flag_q);
    // R7: flag sticks without restart or write
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !restart_i && !wr_i) |=> flag_q);
    // R8: expiry beats a same-cycle write
    p_expire_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (expire_i && !restart_i) |=> flag_q);

endmodule

// File: rtl/wdt_periodic_timer.sv
module wdt_periodic_timer
    import wdt_pkg::*;
#(
    parameter int PRE_W = 11,
    parameter int UNITS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wr_i,
    input  logic [3:0] wdata_i,
    input  logic       tmr_rst_i,
    input  logic       ce_i,
    output logic [3:0] rdata_o,
    output logic       tmout_n_o
);
    wdt_cfg_t cfg_q;
    logic     ce_q;
    logic     ce_rise;
    logic     restart;
    logic     strobe;
    logic     expire;
    logic     flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ce_q  <= 1'b1;
        end else begin
            ce_q <= ce_i;
            if (wr_i) begin
                cfg_q <= unpack_cfg(wdata_i);
            end
        end
    end

    assign ce_rise = ce_i && !ce_q;
    assign restart = tmr_rst_i || ce_rise || (wr_i && !wdata_i[3]) || !cfg_q.en;

    wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .code_i   (cfg_q.code),
        .strobe_o (strobe)
    );

    wdt_unit_counter #(.UNITS(UNITS)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .strobe_i  (strobe),
        .expire_o  (expire)
    );

    wdt_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .expire_i  (expire),
        .wr_i      (wr_i),
        .flag_o    (flag)
    );

    assign rdata_o   = read_word(cfg_q, flag);
    assign tmout_n_o = ~flag;

    // R3: disabled timer never flags
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |=> !flag);
    // R2: write stores the enable bit
    p_write_en_r2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (cfg_q.en == $past(wdata_i[3])));
    // R6: chip-enable rising edge clears the flag
    p_ce_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (ce_i && !ce_q) |=> tmout_n_o);

endmodule

// File: tb/wdt_periodic_timer_tb.sv
`timescale 1ns/1ps
module wdt_periodic_timer_tb;
    localparam int PRE_W = 7;
    localparam int UNITS = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       tick_i = 1'b1;
    logic       wr_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic       tmr_rst_i = 1'b0;
    logic       ce_i = 1'b0;
    logic [3:0] rdata_o;
    logic       tmout_n_o;

    wdt_periodic_timer #(.PRE_W(PRE_W), .UNITS(UNITS)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .tmr_rst_i(tmr_rst_i), .ce_i(ce_i), .rdata_o(rdata_o), .tmout_n_o(tmout_n_o)
    );

    int vectors = 0;
    int miscompares = 0;

    // Behavioural reference model
    logic m_en = 0, m_flag = 0, m_ce_prev = 1;
    int   m_code = 0, m_units = 0, m_ticks = 0;

    always @(posedge clk) begin
        int  u;
        logic rs, bnd, exp_now;
        if (rst) begin
            m_en = 0; m_code = 0; m_flag = 0; m_units = 0; m_ticks = 0; m_ce_prev = 1;
        end else begin
            u   = 1 << (PRE_W - m_code);
            rs  = tmr_rst_i || (ce_i && !m_ce_prev) || (wr_i && !wdata_i[3]) || !m_en;
            bnd = tick_i && ((m_ticks % u) == u - 1);
            exp_now = 0;
            if (rs) begin
                m_units = 0; m_flag = 0;
            end else begin
                if (bnd) begin
                    if (m_units == UNITS - 1) begin m_units = 0; exp_now = 1; end
                    else m_units = m_units + 1;
                end
                if (exp_now) m_flag = 1;
                else if (wr_i) m_flag = 0;
            end
            if (tick_i) m_ticks = (m_ticks + 1) % (1 << PRE_W);
            if (wr_i) begin m_en = wdata_i[3]; m_code = int'(wdata_i[2:0]); end
            m_ce_prev = ce_i;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (rdata_o[3] !== m_en || rdata_o[2:1] !== 2'b00) begin
                miscompares++;
                $display("FAIL R2 rdata[3:1] actual=%b expected=%b", rdata_o[3:1], {m_en, 2'b00});
            end
            if (rdata_o[0] !== m_flag) begin
                miscompares++;
                $display("FAIL R7 flag actual=%b expected=%b", rdata_o[0], m_flag);
            end
            if (tmout_n_o !== ~m_flag) begin
                miscompares++;
                $display("FAIL R7 tmout_n actual=%b expected=%b", tmout_n_o, ~m_flag);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_range(input string tag, input int act, input int lo, input int hi);
        vectors++;
        if (act < lo || act > hi) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write(input logic [3:0] d);
        @(negedge clk); wr_i = 1'b1; wdata_i = d;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic pulse_tmr();
        @(negedge clk); tmr_rst_i = 1'b1;
        @(negedge clk); tmr_rst_i = 1'b0;
    endtask

    task automatic wait_low(output int k);
        k = 0;
        while (tmout_n_o && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    int k;

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        check("R1 rdata after reset", int'(rdata_o), 0);
        check("R1 tmout_n after reset", int'(tmout_n_o), 1);

        // code 3: unit 16 ticks, cycle 160
        write(4'b1011);
        check("R2 period bits not read back", int'(rdata_o), 4'b1000);
        pulse_tmr();
        wait_low(k);
        check_range("R5 first expiry after timer reset, code 3", k, 145, 160);
        check("R2 flag on bit 0", int'(rdata_o), 4'b1001);
        write(4'b1011);
        wait_low(k);
        check("R4 free-running cycle, code 3", k, 158);
        cyc(400);
        check("R7 flag holds without write", int'(tmout_n_o), 0);
        write(4'b1011);
        check("R7 write clears flag", int'(tmout_n_o), 1);

        // code 7: strobe on every tick
        write(4'b1111);
        pulse_tmr();
        wait_low(k);
        check("R5 exact expiry, code 7", k, 10);
        write(4'b1111);
        wait_low(k);
        check("R4 free-running cycle, code 7", k, 8);

        // R8: restart on the expiry edge
        pulse_tmr();
        cyc(8);
        pulse_tmr();
        check("R8 restart beats expiry", int'(tmout_n_o), 1);
        wait_low(k);
        check("R8 full count after collision", k, 10);
        // R8: write on the expiry edge
        pulse_tmr();
        cyc(8);
        write(4'b1111);
        check("R8 expiry beats write", int'(tmout_n_o), 0);

        // R3 / R6: disable
        write(4'b0111);
        check("R6 disable write clears flag", int'(tmout_n_o), 1);
        cyc(300);
        check("R3 disabled pin high", int'(tmout_n_o), 1);
        check("R3 disabled rdata", int'(rdata_o), 0);

        // R6: chip-enable rising edge, code 5 (unit 4, cycle 40)
        write(4'b1101);
        cyc(17);
        @(negedge clk); ce_i = 1'b1;
        @(negedge clk);
        wait_low(k);
        check_range("R6 ce rise restart window", k, 37, 40);
        ce_i = 1'b0;

        // R9: no ticks, no expiry
        write(4'b1111);
        @(negedge clk); tick_i = 1'b0;
        pulse_tmr();
        cyc(100);
        check("R9 no expiry without ticks", int'(tmout_n_o), 1);
        tick_i = 1'b1;
        wait_low(k);
        check("R9 count resumes with ticks", k, 10);

        // Mixed traffic, judged by the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            tick_i    = ($urandom % 3) != 0;
            tmr_rst_i = ($urandom % 97) == 0;
            ce_i      = ($urandom % 150) == 0 ? ~ce_i : ce_i;
            wr_i      = ($urandom % 61) == 0;
            wdata_i   = {($urandom % 8) != 0, 3'(5 + ($urandom % 3))};
        end
        @(negedge clk);
        wr_i = 0; tmr_rst_i = 0;
        cyc(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired, run hung");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule